// File: doc/BRIEF.md
# Early-Release Sync Word Injector

This block pads the configuration data stream of a partially configured device until the device reports that it has reached its early user state. A single start pulse launches the sequence. The block first reads the current clock-to-data ratio setting and keeps a copy. It then forces the ratio to the x1 code and begins sending filler words. Each filler word is all ones, and consecutive words are spaced by a fixed pause.

Before each word the block samples the early-user status input. When that input is high, no further word is sent. The saved ratio is written back and a done pulse is raised. The number of filler words accepted downstream is then available on the count output. If the status never rises within the time limit, the block still restores the ratio and then ends with done and timeout raised together.

The millisecond timebase, the time limit and the inter-word pause all derive from one cycle prescaler. A simulation can therefore use short values.

Top module: `sync_word_injector`

## Requirements
- R1: After reset the block is idle: `word_valid_o`, `done_o`, `timeout_o` and `ratio_we_o` are low and `count_o` is zero.
- R2: On `start_i` while idle, the block captures `ratio_rd_i`. It then writes the x1 code (value 0) through `ratio_wr_o`/`ratio_we_o` before the first word is offered, so the ratio field holds 0 whenever a word is accepted.
- R3: Every offered word equals 32'hFFFFFFFF. Once raised, `word_valid_o` stays high with the same word until `word_ready_i` accepts it.
- R4: The early-user input is sampled before each word. If it is high at that point, no further word is offered. If it is already high at start, zero words are sent.
- R5: A word is accepted on a cycle where both valid and ready are high. After each accepted word, with ready held high, `word_valid_o` is low for exactly GAP_TICKS*TICK_CYCLES+1 cycles before the next word.
- R6: `count_o` is cleared at start, steps by one per accepted word, and holds its final value after done.
- R7: On success the captured ratio is written back before `done_o` pulses for one cycle with `timeout_o` low.
- R8: If LIMIT_MS timebase ticks pass without the early-user flag, the run ends, even while stalled on a word with ready low. The captured ratio is written back, and `done_o` and `timeout_o` pulse high together.
- R9: `start_i` is ignored while a run is in progress: it neither clears the count nor re-captures the ratio.
- R10: A timeout never ends a run sooner than LIMIT_MS*TICK_CYCLES cycles after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin injection |
| early_user_i | input | 1 | Device early-user status flag |
| ratio_rd_i | input | RATIO_W | Read-back of the ratio field |
| ratio_wr_o | output | RATIO_W | Value to write into the ratio field |
| ratio_we_o | output | 1 | Write strobe for the ratio field |
| word_o | output | 32 | Filler word toward the data path |
| word_valid_o | output | 1 | Filler word offered |
| word_ready_i | input | 1 | Data path accepts the word |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | With done: run ended by the time limit |
| count_o | output | CNT_W | Number of filler words accepted |

## Verification
A wrong state in the controller shows up at the ports within one inter-word pause. A lost handshake or a miscounted word makes `count_o` disagree with the words seen on the handshake at the very next done pulse. A wrongly saved or forced ratio appears in the modelled ratio field either at the first accepted word or at done. A stuck timebase shows either as a timeout earlier than the limit allows or as a run that never ends. The pause length is measured on every word, so an off-by-one in the gap counter fails on the second word of a run.

// File: rtl/sync_inj_pkg.sv
package sync_inj_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] FILL_WORD = {WORD_W{1'b1}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FORCE,
        ST_CHECK,
        ST_SEND,
        ST_GAP,
        ST_RESTORE
    } inj_state_e;

    typedef struct packed {
        logic capture;
        logic force_x1;
        logic restore;
    } ratio_cmd_t;

    function automatic logic state_busy(input inj_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/sync_inj_timebase.sv
module sync_inj_timebase #(
    parameter int TICK_CYCLES = 100000,
    parameter int LIMIT_MS    = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int MW = $clog2(LIMIT_MS + 1);
    localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYCLES - 1);
    localparam logic [MW-1:0] MS_LIMIT   = MW'(LIMIT_MS);

    logic [PW-1:0] presc_q;
    logic [MW-1:0] ms_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            presc_q <= '0;
            ms_q    <= '0;
        end else if (run_i) begin
            if (presc_q == PRESC_LAST) begin
                presc_q <= '0;
                if (ms_q != MS_LIMIT) ms_q <= ms_q + 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    assign expired_o = (ms_q == MS_LIMIT);

    a_r8_expired_sticky: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !clear_i) |=> expired_o);
    a_r10_clear_resets: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !expired_o);

endmodule

// File: rtl/sync_inj_gap.sv
module sync_inj_gap #(
    parameter int GAP_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic elapsed_o
);
    localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign elapsed_o = active_i && (cnt_q == GAP_LAST);

    a_r5_gap_from_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(active_i) |-> !elapsed_o || (GAP_CYCLES == 1));

endmodule

// File: rtl/sync_inj_ratio.sv
module sync_inj_ratio
    import sync_inj_pkg::*;
#(
    parameter int RATIO_W = 2,
    parameter int RATIO_X1 = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  ratio_cmd_t         cmd_i,
    input  logic [RATIO_W-1:0] ratio_rd_i,
    output logic [RATIO_W-1:0] ratio_wr_o,
    output logic               ratio_we_o
);
    localparam logic [RATIO_W-1:0] X1_CODE = RATIO_W'(RATIO_X1);

    logic [RATIO_W-1:0] saved_q;

    always_ff @(posedge clk) begin
        if (rst)               saved_q <= '0;
        else if (cmd_i.capture) saved_q <= ratio_rd_i;
    end

    always_comb begin
        ratio_we_o = cmd_i.force_x1 || cmd_i.restore;
        ratio_wr_o = cmd_i.force_x1 ? X1_CODE : saved_q;
    end

    a_r2_single_cmd: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_i.capture, cmd_i.force_x1, cmd_i.restore}) <= 1);
    a_r9_saved_held: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_i.capture) |-> $stable(saved_q));

endmodule

// File: rtl/sync_word_injector.sv
module sync_word_injector
    import sync_inj_pkg::*;
#(
    parameter int TICK_CYCLES = 100000,
    parameter int LIMIT_MS    = 1000,
    parameter int GAP_TICKS   = 1,
    parameter int RATIO_W     = 2,
    parameter int RATIO_X1    = 0,
    parameter int CNT_W       = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               early_user_i,
    input  logic [RATIO_W-1:0] ratio_rd_i,
    output logic [RATIO_W-1:0] ratio_wr_o,
    output logic               ratio_we_o,
    output logic [31:0]        word_o,
    output logic               word_valid_o,
    input  logic               word_ready_i,
    output logic               done_o,
    output logic               timeout_o,
    output logic [CNT_W-1:0]   count_o
);
    localparam int GAP_CYCLES = GAP_TICKS * TICK_CYCLES;

    inj_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             to_flag_q, to_flag_d;
    logic             done_q, to_q;
    logic             expired, gap_done;
    ratio_cmd_t       rcmd;

    sync_inj_timebase #(
        .TICK_CYCLES(TICK_CYCLES),
        .LIMIT_MS   (LIMIT_MS)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (state_q == ST_IDLE),
        .run_i    (state_busy(state_q)),
        .expired_o(expired)
    );

    sync_inj_gap #(
        .GAP_CYCLES(GAP_CYCLES)
    ) u_gap (
        .clk      (clk),
        .rst      (rst),
        .active_i (state_q == ST_GAP),
        .elapsed_o(gap_done)
    );

    assign rcmd.capture  = (state_q == ST_IDLE) && start_i;
    assign rcmd.force_x1 = (state_q == ST_FORCE);
    assign rcmd.restore  = (state_q == ST_RESTORE);

    sync_inj_ratio #(
        .RATIO_W (RATIO_W),
        .RATIO_X1(RATIO_X1)
    ) u_ratio (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (rcmd),
        .ratio_rd_i(ratio_rd_i),
        .ratio_wr_o(ratio_wr_o),
        .ratio_we_o(ratio_we_o)
    );

    always_comb begin
        state_d   = state_q;
        to_flag_d = to_flag_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d   = ST_FORCE;
                    to_flag_d = 1'b0;
                end
            end
            ST_FORCE: state_d = ST_CHECK;
            ST_CHECK: begin
                if (early_user_i) begin
                    state_d = ST_RESTORE;
                end else if (expired) begin
                    state_d   = ST_RESTORE;
                    to_flag_d = 1'b1;
                end else begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (word_ready_i) begin
                    state_d = ST_GAP;
                end else if (expired) begin
                    state_d   = ST_RESTORE;
                    to_flag_d = 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_done) state_d = ST_CHECK;
            end
            ST_RESTORE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            to_flag_q <= 1'b0;
            count_q   <= '0;
            done_q    <= 1'b0;
            to_q      <= 1'b0;
        end else begin
            state_q   <= state_d;
            to_flag_q <= to_flag_d;
            done_q    <= (state_q == ST_RESTORE);
            to_q      <= (state_q == ST_RESTORE) && to_flag_q;
            if (state_q == ST_IDLE && start_i)
                count_q <= '0;
            else if (state_q == ST_SEND && word_ready_i)
                count_q <= count_q + 1'b1;
        end
    end

    assign word_valid_o = (state_q == ST_SEND);
    assign word_o       = FILL_WORD;
    assign done_o       = done_q;
    assign timeout_o    = to_q;
    assign count_o      = count_q;

    a_r3_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && !word_ready_i && !expired) |=> word_valid_o);
    a_r4_no_word_after_flag: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && early_user_i) |=> !word_valid_o);
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && word_ready_i) |=> count_o == $past(count_o) + 1'b1);
    a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> done_o);
    a_r7_restore_before_done: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(ratio_we_o));
    a_r9_count_kept_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && !(word_valid_o && word_ready_i)) |=> $stable(count_o));

endmodule

// File: tb/sync_word_injector_tb_top.sv
module sync_word_injector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 4;
    localparam int LIMIT      = 30;
    localparam int GAPT       = 2;
    localparam int GAPC       = GAPT * TICK;
    localparam int RW         = 2;
    localparam int CW         = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          early_user_i = 1'b0;
    logic [RW-1:0] ratio_reg = '0;
    logic [RW-1:0] ratio_wr_o;
    logic          ratio_we_o;
    logic [31:0]   word_o;
    logic          word_valid_o;
    logic          word_ready_i = 1'b1;
    logic          done_o, timeout_o;
    logic [CW-1:0] count_o;

    logic          load_en = 1'b0;
    logic [RW-1:0] load_val = '0;
    int            rdy_mode = 0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int hs_count = 0;
    int low_run = 0;
    int done_seen = 0;
    int start_cyc = 0;
    logic prev_valid = 1'b0, prev_ready = 1'b0;

    typedef struct {
        int          words;
        bit          timeout;
        logic [RW-1:0] ratio;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_word_injector #(
        .TICK_CYCLES(TICK),
        .LIMIT_MS   (LIMIT),
        .GAP_TICKS  (GAPT),
        .RATIO_W    (RW),
        .RATIO_X1   (0),
        .CNT_W      (CW)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .early_user_i(early_user_i),
        .ratio_rd_i  (ratio_reg),
        .ratio_wr_o  (ratio_wr_o),
        .ratio_we_o  (ratio_we_o),
        .word_o      (word_o),
        .word_valid_o(word_valid_o),
        .word_ready_i(word_ready_i),
        .done_o      (done_o),
        .timeout_o   (timeout_o),
        .count_o     (count_o)
    );

    // ratio field model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load_en)         ratio_reg <= load_val;
        else if (ratio_we_o) ratio_reg <= ratio_wr_o;
    end

    // ready driver
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: word_ready_i = 1'b1;
            1: word_ready_i = (cyc % 4 == 0);
            default: word_ready_i = 1'b0;
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_valid && !prev_ready && !done_o && (timeout_o == 1'b0) && dut_i.state_q == dut_i.state_q) begin
                if (!word_valid_o && !(rdy_mode == 2)) check(0, "R3 valid dropped", 0, 1);
            end
            if (word_valid_o)
                check(word_o == 32'hFFFFFFFF, "R3 word value", int'(word_o[15:0]), 16'hFFFF);
            if (word_valid_o && word_ready_i) begin
                check(ratio_reg == 0, "R2 ratio forced x1", int'(ratio_reg), 0);
                if (hs_count > 0 && rdy_mode == 0)
                    check(low_run == GAPC + 1, "R5 gap length", low_run, GAPC + 1);
                hs_count = hs_count + 1;
                low_run = 0;
            end else if (!word_valid_o && hs_count > 0) begin
                low_run = low_run + 1;
            end
            if (done_o) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(count_o == CW'(hs_count), "R6 count vs handshakes", int'(count_o), hs_count);
                    if (e.words >= 0)
                        check(count_o == CW'(e.words), "R4 words sent", int'(count_o), e.words);
                    check(timeout_o == e.timeout, e.timeout ? "R8 timeout flag" : "R7 no timeout",
                          int'(timeout_o), int'(e.timeout));
                    check(ratio_reg == e.ratio, e.timeout ? "R8 ratio restored" : "R7 ratio restored",
                          int'(ratio_reg), int'(e.ratio));
                    if (e.timeout)
                        check(cyc - start_cyc >= LIMIT * TICK, "R10 timeout not early",
                              cyc - start_cyc, LIMIT * TICK);
                end
                hs_count = 0;
                low_run = 0;
                done_seen = done_seen + 1;
            end
            prev_valid = word_valid_o;
            prev_ready = word_ready_i;
        end
    end

    task automatic run_case(input logic [RW-1:0] orig, input int k, input int rmode,
                            input bit pre, input bit exp_to, input bit restart_mid);
        exp_t e;
        int ds;
        @(posedge clk); #1;
        load_en = 1'b1; load_val = orig;
        @(posedge clk); #1;
        load_en = 1'b0;
        early_user_i = pre;
        rdy_mode = rmode;
        e.words = exp_to ? -1 : k;
        e.timeout = exp_to;
        e.ratio = orig;
        exp_q.push_back(e);
        ds = done_seen;
        @(posedge clk); #1;
        start_cyc = cyc;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (restart_mid) begin
            wait (hs_count >= 1);
            @(posedge clk); #1;
            start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        if (!exp_to && !pre) begin
            wait (hs_count >= k);
            @(posedge clk); #1;
            early_user_i = 1'b1;
        end
        wait (done_seen > ds);
        repeat (3) @(posedge clk);
        #2;
        if (!exp_to)
            check(count_o == CW'(k), "R6 count held after done", int'(count_o), k);
        check(!word_valid_o && !ratio_we_o, "R7 idle after done", int'(word_valid_o), 0);
        early_user_i = 1'b0;
        rdy_mode = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!word_valid_o && !done_o && !timeout_o && !ratio_we_o, "R1 reset outputs", int'(word_valid_o), 0);
        check(count_o == 0, "R1 reset count", int'(count_o), 0);
        run_case(2'd3, 3, 0, 1'b0, 1'b0, 1'b0);  // R7 success, R5 gaps
        run_case(2'd2, 0, 0, 1'b1, 1'b0, 1'b0);  // R4 flag high at start
        run_case(2'd1, 5, 1, 1'b0, 1'b0, 1'b0);  // R3 backpressure
        run_case(2'd2, 4, 0, 1'b0, 1'b0, 1'b1);  // R9 restart ignored
        run_case(2'd3, 0, 0, 1'b0, 1'b1, 1'b0);  // R8 timeout with words
        run_case(2'd1, 0, 2, 1'b0, 1'b1, 1'b0);  // R8 timeout while stalled
        check(exp_q.size() == 0, "R7 all runs completed", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule